// File: doc/BRIEF.md
# SHA-256 Block Compression Engine with Split Feed-Forward

This block performs the 64-round SHA-256 compression of one 512-bit block. While it runs, it takes one message-schedule word per cycle from an outside scheduler. The round constants come from an internal table. The engine keeps the eight chaining words between blocks, so a message of several blocks is processed one block at a time. For the second and later blocks the caller clears the first-block flag when it issues the start.

The engine does not perform the eight chaining additions in one wide step. It has two adders, and they run during the last four rounds. Each adder sums a chaining word with the working variable that will occupy that position once the block completes. After the last round, a one-cycle done pulse marks the finished result. The digest is then available in two forms:

- on a 256-bit parallel output;
- as single 32-bit words, one per read request, starting with the most significant word.

Top module: `sha256_compress`

## Requirements
- R1: After reset, busy, w_take, done and rd_valid are 0, and the digest output holds the SHA-256 initial words 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19 (first word in bits 255:224).
- R2: A start while idle with first_blk=1 loads the initial words into the chaining and working registers at that single edge. From the next cycle, w_take is 1 for exactly 64 consecutive cycles, and the word on w_in in the t-th of those cycles is used as W_t.
- R3: Each round applies the standard SHA-256 update (T1, T2, a = T1+T2, e = d+T1, the others shift). For a padded one-block message the digest equals the standard SHA-256 value, e.g. "abc" gives ba7816bf...f20015ad.
- R4: The chaining words stay unchanged through rounds 0 to 59. At the edge ending round 60, words 3 and 7 take their final values. Round 61 finalises words 2 and 6, round 62 words 1 and 5, and round 63 words 0 and 4. No other word changes at those edges.
- R5: done is a single-cycle pulse in the cycle after the edge that ends round 63. busy and w_take fall at that same edge.
- R6: A start with first_blk=0 continues from the current chaining words. A two-block message yields the standard SHA-256 digest.
- R7: A start (with either flag value) while busy is ignored: the block in progress completes with an unchanged result.
- R8: A rd_en while idle returns one digest word on rd_word, with rd_valid=1, in the next cycle. The words come in order H0..H7, starting at H0 after each completed block and wrapping to H0 after the eighth read.
- R9: A rd_en while busy is ignored: rd_valid stays 0 and the read position is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin compression of a block (taken only when idle) |
| first_blk | input | 1 | 1: begin a new message from the initial words; 0: chain from the current digest |
| w_in | input | 32 | Schedule word for the current round |
| w_take | output | 1 | Round in progress; w_in is consumed this cycle |
| busy | output | 1 | Engine is compressing a block |
| done | output | 1 | One-cycle pulse when the digest is final |
| rd_en | input | 1 | Request the next digest word |
| rd_word | output | 32 | Word returned by the last read |
| rd_valid | output | 1 | rd_word is fresh this cycle |
| digest | output | 256 | Chaining words H0..H7, H0 in the upper bits |

## Verification
The assertions assume that the outside scheduler delivers a word on every cycle w_take is high. They place no limits on when start or rd_en may arrive: both may come at any time, including mid-block. The stimulus always supplies the full 64-word schedule back to back, as computed in the bench. It also deliberately places a start and a read in the middle of a block, to confirm that both are dropped. The bench computes expected digests with its own model of the algorithm and anchors that model on two published test vectors.

// File: rtl/sha256_cmp_pkg.sv
`timescale 1ns/1ps
package sha256_cmp_pkg;
    localparam int WORD_W  = 32;
    localparam int NVARS   = 8;
    localparam int ROUNDS  = 64;
    localparam int RND_W   = $clog2(ROUNDS);
    localparam int DIG_WORDS = 8;
    localparam int PTR_W   = $clog2(DIG_WORDS);
    localparam int FF_SLOTS = NVARS / 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NVARS-1:0][WORD_W-1:0] word_vec_t;

    typedef enum logic {PH_IDLE = 1'b0, PH_ROUND = 1'b1} phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [RND_W-1:0]    t;
        word_vec_t           wv;
        word_vec_t           hv;
        logic [PTR_W-1:0]    rp;
        word_t               rd;
        logic                rv;
        logic                dn;
    } cmp_state_t;

    localparam word_vec_t IV_VEC = {
        32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

    function automatic word_t rotr(input word_t x, input int n);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} >> n;
        return dbl[WORD_W-1:0];
    endfunction

    function automatic word_t big_s0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t f_ch(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t f_maj(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction
endpackage

// File: rtl/sha256_kconst.sv
`timescale 1ns/1ps
module sha256_kconst
    import sha256_cmp_pkg::*;
(
    input  logic [RND_W-1:0] idx,
    output word_t            k
);
    always_comb begin
        case (idx)
            6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491;
            6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
            6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1;
            6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
            6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01;
            6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
            6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe;
            6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
            6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786;
            6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
            6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa;
            6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
            6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d;
            6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
            6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147;
            6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
            6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138;
            6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
            6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb;
            6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
            6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b;
            6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
            6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624;
            6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
            6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08;
            6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
            6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a;
            6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
            6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f;
            6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
            6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb;
            6'd62: k = 32'hbef9a3f7; default: k = 32'hc67178f2;
        endcase
    end
endmodule

// File: rtl/sha256_round.sv
`timescale 1ns/1ps
module sha256_round
    import sha256_cmp_pkg::*;
(
    input  word_vec_t cur,
    input  word_t     k,
    input  word_t     w,
    output word_vec_t nxt
);
    word_t t1, t2;

    always_comb begin
        t1 = cur[7] + big_s1(cur[4]) + f_ch(cur[4], cur[5], cur[6]) + k + w;
        t2 = big_s0(cur[0]) + f_maj(cur[0], cur[1], cur[2]);
        nxt    = cur;
        nxt[0] = t1 + t2;
        nxt[4] = cur[3] + t1;
        for (int i = 1; i < NVARS; i++) begin
            if (i != 4) nxt[i] = cur[i-1];
        end
    end
endmodule

// File: rtl/sha256_ffadd.sv
`timescale 1ns/1ps
module sha256_ffadd
    import sha256_cmp_pkg::*;
(
    input  logic                          en,
    input  logic [$clog2(FF_SLOTS)-1:0]   slot,
    input  word_vec_t                     hv,
    input  word_t                         new_a,
    input  word_t                         new_e,
    output word_vec_t                     hv_nxt
);
    localparam int SL_W = $clog2(FF_SLOTS);

    logic [SL_W-1:0] lane;
    word_t           sum_lo, sum_hi;

    always_comb begin
        lane   = SL_W'(FF_SLOTS - 1) - slot;
        sum_lo = hv[lane] + new_a;
        sum_hi = hv[lane + SL_W'(0) + FF_SLOTS] + new_e;
    end

    for (genvar i = 0; i < FF_SLOTS; i++) begin : g_lane
        assign hv_nxt[i]            = (en && lane == SL_W'(i)) ? sum_lo : hv[i];
        assign hv_nxt[i + FF_SLOTS] = (en && lane == SL_W'(i)) ? sum_hi : hv[i + FF_SLOTS];
    end
endmodule

// File: rtl/sha256_compress.sv
`timescale 1ns/1ps
module sha256_compress
    import sha256_cmp_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         first_blk,
    input  logic [31:0]  w_in,
    output logic         w_take,
    output logic         busy,
    output logic         done,
    input  logic         rd_en,
    output logic [31:0]  rd_word,
    output logic         rd_valid,
    output logic [255:0] digest
);
    localparam logic [RND_W-1:0] LAST_T   = RND_W'(ROUNDS - 1);
    localparam logic [RND_W-1:0] FF_FIRST = RND_W'(ROUNDS - FF_SLOTS);
    localparam logic [PTR_W-1:0] LAST_RP  = PTR_W'(DIG_WORDS - 1);

    cmp_state_t s_q, s_d;
    word_t      k_cur;
    word_vec_t  rnd_nxt, ff_hv;
    logic       ff_en;

    sha256_kconst u_kconst (.idx(s_q.t), .k(k_cur));

    sha256_round u_round (.cur(s_q.wv), .k(k_cur), .w(w_in), .nxt(rnd_nxt));

    assign ff_en = (s_q.ph == PH_ROUND) && (s_q.t >= FF_FIRST);

    sha256_ffadd u_ffadd (
        .en(ff_en), .slot(s_q.t[$clog2(FF_SLOTS)-1:0]), .hv(s_q.hv),
        .new_a(rnd_nxt[0]), .new_e(rnd_nxt[FF_SLOTS]), .hv_nxt(ff_hv));

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        s_d.dn = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph = PH_ROUND;
                    s_d.t  = '0;
                    s_d.rp = '0;
                    if (first_blk) begin
                        s_d.hv = IV_VEC;
                        s_d.wv = IV_VEC;
                    end else begin
                        s_d.wv = s_q.hv;
                    end
                end else if (rd_en) begin
                    s_d.rd = s_q.hv[s_q.rp];
                    s_d.rv = 1'b1;
                    s_d.rp = (s_q.rp == LAST_RP) ? '0 : s_q.rp + PTR_W'(1);
                end
            end
            default: begin
                s_d.wv = rnd_nxt;
                s_d.hv = ff_hv;
                s_d.t  = s_q.t + RND_W'(1);
                if (s_q.t == LAST_T) begin
                    s_d.ph = PH_IDLE;
                    s_d.dn = 1'b1;
                    s_d.rp = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph <= PH_IDLE;
            s_q.t  <= '0;
            s_q.wv <= IV_VEC;
            s_q.hv <= IV_VEC;
            s_q.rp <= '0;
            s_q.rd <= '0;
            s_q.rv <= 1'b0;
            s_q.dn <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign w_take   = (s_q.ph == PH_ROUND);
    assign busy     = (s_q.ph == PH_ROUND);
    assign done     = s_q.dn;
    assign rd_word  = s_q.rd;
    assign rd_valid = s_q.rv;

    for (genvar i = 0; i < NVARS; i++) begin : g_dig
        assign digest[WORD_W*(NVARS-i)-1 -: WORD_W] = s_q.hv[i];
    end

    // R2: a fresh message loads the initial words in one edge
    p_iv_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && first_blk) |=> (digest == IV_VEC_FLAT()) && w_take);

    // R2: rounds follow each other without a gap until the last
    p_take_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (w_take && s_q.t != LAST_T) |=> w_take && (s_q.t == $past(s_q.t) + RND_W'(1)));

    // R4: chaining words held through the early rounds
    p_h_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_take && s_q.t < FF_FIRST) |=> $stable(digest));

    // R5: completion pulse after the final round
    p_done_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_take && s_q.t == LAST_T) |=> done && !busy);

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: start while busy does not restart the round count
    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && s_q.t != LAST_T) |=> busy && s_q.t != '0);

    // R9: reads while busy are dropped
    p_rd_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> !rd_valid && $stable(s_q.rp));

    function automatic logic [255:0] IV_VEC_FLAT();
        logic [255:0] f;
        for (int i = 0; i < NVARS; i++) f[WORD_W*(NVARS-i)-1 -: WORD_W] = IV_VEC[i];
        return f;
    endfunction
endmodule

// File: tb/sha256_compress_bench.sv
`timescale 1ns/1ps
module sha256_compress_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         first_blk = 1'b0;
    logic [31:0]  w_in = '0;
    logic         w_take, busy, done, rd_en, rd_valid;
    logic [31:0]  rd_word;
    logic [255:0] digest;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] kt [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};
    logic [31:0] iv [8] = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                            32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

    logic [31:0] mh [8];
    logic [31:0] blk [16];
    logic [31:0] old_h [8];

    sha256_compress u_sha256_compress (
        .clk(clk), .rst_n(rst_n), .start(start), .first_blk(first_blk), .w_in(w_in),
        .w_take(w_take), .busy(busy), .done(done), .rd_en(rd_en), .rd_word(rd_word),
        .rd_valid(rd_valid), .digest(digest));

    always #4 clk = ~clk;

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] pack(input logic [31:0] h [8]);
        logic [255:0] f;
        for (int i = 0; i < 8; i++) f[255-32*i -: 32] = h[i];
        return f;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_block(input bit first, input bit inj);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] t1, t2, s0, s1;
        logic [255:0] mid;
        for (int t = 0; t < 64; t++) begin
            if (t < 16) w[t] = blk[t];
            else begin
                s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
                s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
                w[t] = w[t-16] + s0 + w[t-7] + s1;
            end
        end
        if (first) for (int i = 0; i < 8; i++) mh[i] = iv[i];
        for (int i = 0; i < 8; i++) begin old_h[i] = mh[i]; v[i] = mh[i]; end
        for (int t = 0; t < 64; t++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25)) + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[t] + w[t];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22)) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) mh[i] = mh[i] + v[i];

        @(negedge clk); start = 1'b1; first_blk = first;
        @(posedge clk); @(negedge clk); start = 1'b0; first_blk = 1'b0;
        chk(w_take && busy, "R2 take after start", {254'd0, w_take, busy}, 256'd3);
        chk(digest == pack(old_h), "R2 chaining at load", digest, pack(old_h));
        for (int t = 0; t < 64; t++) begin
            w_in = w[t];
            if (inj && t == 20) rd_en = 1'b1;
            if (inj && t == 21) rd_en = 1'b0;
            if (inj && t == 30) begin start = 1'b1; first_blk = 1'b1; end
            if (inj && t == 31) begin start = 1'b0; first_blk = 1'b0; end
            @(posedge clk); @(negedge clk);
            if (inj && t == 20) chk(!rd_valid, "R9 read while busy", {255'd0, rd_valid}, 256'd0);
            if (t == 59) chk(digest == pack(old_h), "R4 hold to round 59", digest, pack(old_h));
            if (t >= 60) begin
                for (int i = 0; i < 4; i++) begin
                    mid[255-32*i -: 32]     = (i >= 63 - t) ? mh[i]   : old_h[i];
                    mid[255-32*(i+4) -: 32] = (i >= 63 - t) ? mh[i+4] : old_h[i+4];
                end
                chk(digest == mid, "R4 staggered feed-forward", digest, mid);
            end
            if (t < 63) chk(w_take, "R2 take run", {255'd0, w_take}, 256'd1);
        end
        chk(done && !busy && !w_take, "R5 done after round 63", {253'd0, done, busy, w_take}, 256'd4);
        chk(digest == pack(mh), "R3 R6 digest vs model", digest, pack(mh));
        @(posedge clk); @(negedge clk);
        chk(!done, "R5 done single pulse", {255'd0, done}, 256'd0);
    endtask

    initial begin
        logic [31:0] seed;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) mh[i] = iv[i];
        chk(!busy && !w_take && !done && !rd_valid, "R1 reset outputs",
            {252'd0, busy, w_take, done, rd_valid}, 256'd0);
        chk(digest == pack(iv), "R1 reset digest", digest, pack(iv));

        // R3: one-block "abc"
        for (int i = 0; i < 16; i++) blk[i] = 32'd0;
        blk[0] = 32'h61626380; blk[15] = 32'h00000018;
        run_block(1'b1, 1'b0);
        chk(digest == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
            "R3 abc vector", digest, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

        // R8: serial readout with wrap
        for (int r = 0; r < 9; r++) begin
            rd_en = 1'b1;
            @(posedge clk); @(negedge clk);
            chk(rd_valid && rd_word == mh[r % 8], "R8 serial read",
                {223'd0, rd_valid, rd_word}, {223'd0, 1'b1, mh[r % 8]});
        end
        rd_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(!rd_valid, "R8 valid drops", {255'd0, rd_valid}, 256'd0);

        // R6 R7 R9: two-block message, mid-block start and read injected
        for (int n = 0; n < 14; n++)
            blk[n] = {8'h61 + 8'(n), 8'h62 + 8'(n), 8'h63 + 8'(n), 8'h64 + 8'(n)};
        blk[14] = 32'h80000000; blk[15] = 32'd0;
        run_block(1'b1, 1'b0);
        for (int i = 0; i < 16; i++) blk[i] = 32'd0;
        blk[15] = 32'h000001c0;
        run_block(1'b0, 1'b1);
        chk(digest == 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1,
            "R6 R7 two-block vector", digest, 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1);

        // R3 R6: sweep of pseudo-random chained blocks
        seed = 32'h1234abcd;
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < 16; i++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                blk[i] = seed;
            end
            run_block(b == 0 || b == 3, b == 4);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #1600000;
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule